// File: doc/BRIEF.md
# Three-Component Color Matrix Converter

This block maps one pixel, carried as three color components, from one color space into another on every clock cycle. Each output component is a weighted sum of the three input components plus a constant. The three weights and the constant for each output row come from a 3x4 matrix of real-valued parameters. The matrix is turned into fixed-point integers at elaboration time, and there is no run-time loading. With the default parameters the block converts 8-bit computer-range RGB into standard-definition YCbCr.

The result leaves the block at full precision, with no rounding, truncation or saturation. A downstream stage narrows the width. An optional valid strobe travels alongside the data so that the output valid marks the matching result. A clock enable can freeze the entire pipeline. There is also a synchronous clear and an asynchronous active-low reset.

Top module: `color_matrix_conv`

## Requirements
- R1: With the default parameters (unsigned 8-bit inputs, 18-bit coefficients, binary point 10), `out_c0` equals 263*c0 + 516*c1 + 100*c2 + 16384, read as a two's-complement integer.
- R2: With the default parameters, `out_c1` equals -152*c0 - 298*c1 + 450*c2 + 131072 and `out_c2` equals 450*c0 - 377*c1 - 73*c2 + 131072.
- R3: Each real coefficient is multiplied by 2^BPOINT and rounded to the nearest integer, with halves rounded away from zero. The constant column is scaled by the same factor. For example, 0.439 becomes 450 and -0.071 becomes -73.
- R4: The output components are two's-complement values of width IN_W + COEF_W + 2, and no intermediate sum wraps for the coefficient set in use.
- R5: A pixel presented with `clk_en` high appears on all three outputs together, exactly 4 enabled clock edges later. A new pixel is accepted on every enabled edge.
- R6: `out_vld` equals the `in_vld` value that was sampled with the same pixel, delayed by the same 4 enabled edges. The data path runs whether or not `in_vld` is high.
- R7: While `clk_en` is low, every register holds its value and all synchronous inputs are ignored, including `sync_clr`.
- R8: A `sync_clr` sampled high with `clk_en` high empties the pipeline at that edge. Afterwards `out_vld` and the outputs read zero, and no pixel that was in flight appears later.
- R9: `rst_n` low clears every register at once, without waiting for a clock edge.
- R10: When IN_SIGNED is 0, inputs are zero-extended, so a component of 255 counts as +255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes all state |
| sync_clr | input | 1 | Synchronous clear, qualified by clk_en |
| in_vld | input | 1 | Marks a valid input pixel |
| in_c0 | input | IN_W | First input component |
| in_c1 | input | IN_W | Second input component |
| in_c2 | input | IN_W | Third input component |
| out_vld | output | 1 | Marks a valid output pixel |
| out_c0 | output | IN_W+COEF_W+2 | First output component, full precision |
| out_c1 | output | IN_W+COEF_W+2 | Second output component, full precision |
| out_c2 | output | IN_W+COEF_W+2 | Third output component, full precision |

## Verification
The hardest case to reach is a pixel that has been accepted and is still in flight while the clock enable is held low and a clear is asserted at the same time. The stimulus captures a pixel with one enabled edge and then holds `clk_en` low for several cycles with `sync_clr` high and different data on the inputs. It then resumes and expects the original pixel to emerge exactly three enabled edges later. A second sequence loads two pixels, clears with the enable high, and watches that neither one appears. It also watches that zeros, rather than stale products, flow out afterwards.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

    // Scale a real coefficient by 2^bp and round to the nearest integer,
    // halves going away from zero.
    function automatic longint quant_coef(real v, int bp);
        real s;
        s = v;
        for (int i = 0; i < bp; i++) begin
            s = s * 2.0;
        end
        if (s >= 0.0) begin
            return longint'($rtoi($floor(s + 0.5)));
        end
        return -longint'($rtoi($floor(-s + 0.5)));
    endfunction

endpackage

// File: rtl/cmx_vld_pipe.sv
module cmx_vld_pipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic vld_in,
    output logic vld_out
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (clr) begin
            stg_d = '0;
        end else begin
            stg_d = {stg_q[DEPTH-2:0], vld_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else if (en) begin
            stg_q <= stg_d;
        end
    end

    assign vld_out = stg_q[DEPTH-1];

    // Number of uninterrupted enabled, non-clearing edges, saturating at DEPTH.
    logic [CNT_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!en || clr) begin
            run_d = '0;
        end else if (run_q < CNT_W'(DEPTH)) begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == CNT_W'(DEPTH)) |-> (vld_out == $past(vld_in, DEPTH))); // R6

endmodule

// File: rtl/cmx_lane.sv
module cmx_lane #(
    parameter int IN_W   = 8,
    parameter int COEF_W = 18,
    parameter logic signed [COEF_W-1:0] C0 = '0,
    parameter logic signed [COEF_W-1:0] C1 = '0,
    parameter logic signed [COEF_W-1:0] C2 = '0,
    parameter logic signed [IN_W+COEF_W+1:0] OFF = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      clr,
    input  logic signed [IN_W:0]      x0,
    input  logic signed [IN_W:0]      x1,
    input  logic signed [IN_W:0]      x2,
    output logic [IN_W+COEF_W+1:0]    y
);
    localparam int X_W    = IN_W + 1;
    localparam int P_W    = X_W + COEF_W;
    localparam int FULL_W = IN_W + COEF_W + 2;

    typedef struct packed {
        logic signed [P_W-1:0]    p0;
        logic signed [P_W-1:0]    p1;
        logic signed [P_W-1:0]    p2;
        logic signed [FULL_W-1:0] s01;
        logic signed [P_W-1:0]    p2d;
        logic signed [FULL_W-1:0] acc;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.p0  = P_W'(x0) * P_W'(C0);
            st_d.p1  = P_W'(x1) * P_W'(C1);
            st_d.p2  = P_W'(x2) * P_W'(C2);
            st_d.s01 = FULL_W'(st_q.p0) + FULL_W'(st_q.p1);
            st_d.p2d = st_q.p2;
            st_d.acc = st_q.s01 + FULL_W'(st_q.p2d) + OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (en) begin
            st_q <= st_d;
        end
    end

    assign y = st_q.acc;

    logic signed [FULL_W+1:0] wide_sum;
    assign wide_sum = (FULL_W+2)'(st_q.s01) + (FULL_W+2)'(st_q.p2d) + (FULL_W+2)'(OFF);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (wide_sum[FULL_W+1:FULL_W-1] == {3{wide_sum[FULL_W-1]}})); // R4

endmodule

// File: rtl/color_matrix_conv.sv
module color_matrix_conv #(
    parameter int  IN_W      = 8,
    parameter bit  IN_SIGNED = 1'b0,
    parameter int  COEF_W    = 18,
    parameter int  BPOINT    = 10,
    parameter real M00 = 0.257,  parameter real M01 = 0.504,  parameter real M02 = 0.098,  parameter real M03 = 16.0,
    parameter real M10 = -0.148, parameter real M11 = -0.291, parameter real M12 = 0.439,  parameter real M13 = 128.0,
    parameter real M20 = 0.439,  parameter real M21 = -0.368, parameter real M22 = -0.071, parameter real M23 = 128.0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     sync_clr,
    input  logic                     in_vld,
    input  logic [IN_W-1:0]          in_c0,
    input  logic [IN_W-1:0]          in_c1,
    input  logic [IN_W-1:0]          in_c2,
    output logic                     out_vld,
    output logic [IN_W+COEF_W+1:0]   out_c0,
    output logic [IN_W+COEF_W+1:0]   out_c1,
    output logic [IN_W+COEF_W+1:0]   out_c2
);
    localparam int X_W     = IN_W + 1;
    localparam int FULL_W  = IN_W + COEF_W + 2;
    localparam int LATENCY = 4;

    function automatic real coef_at(int r, int c);
        case (r * 4 + c)
            0:  return M00;
            1:  return M01;
            2:  return M02;
            3:  return M03;
            4:  return M10;
            5:  return M11;
            6:  return M12;
            7:  return M13;
            8:  return M20;
            9:  return M21;
            10: return M22;
            default: return M23;
        endcase
    endfunction

    typedef struct packed {
        logic signed [X_W-1:0] a;
        logic signed [X_W-1:0] b;
        logic signed [X_W-1:0] c;
    } pix_t;

    pix_t ext, pix_d, pix_q;

    generate
        if (IN_SIGNED) begin : g_sext
            assign ext = '{a: {in_c0[IN_W-1], in_c0},
                           b: {in_c1[IN_W-1], in_c1},
                           c: {in_c2[IN_W-1], in_c2}};
        end else begin : g_zext
            assign ext = '{a: {1'b0, in_c0},
                           b: {1'b0, in_c1},
                           c: {1'b0, in_c2}};
        end
    endgenerate

    always_comb begin
        pix_d = pix_q;
        if (sync_clr) begin
            pix_d = '0;
        end else begin
            pix_d = ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else if (clk_en) begin
            pix_q <= pix_d;
        end
    end

    logic [FULL_W-1:0] row_y [3];

    for (genvar r = 0; r < 3; r++) begin : g_row
        localparam logic signed [COEF_W-1:0] K0 = COEF_W'(cmx_pkg::quant_coef(coef_at(r, 0), BPOINT));
        localparam logic signed [COEF_W-1:0] K1 = COEF_W'(cmx_pkg::quant_coef(coef_at(r, 1), BPOINT));
        localparam logic signed [COEF_W-1:0] K2 = COEF_W'(cmx_pkg::quant_coef(coef_at(r, 2), BPOINT));
        localparam logic signed [FULL_W-1:0] KO = FULL_W'(cmx_pkg::quant_coef(coef_at(r, 3), BPOINT));

        cmx_lane #(
            .IN_W   (IN_W),
            .COEF_W (COEF_W),
            .C0     (K0),
            .C1     (K1),
            .C2     (K2),
            .OFF    (KO)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (clk_en),
            .clr   (sync_clr),
            .x0    (pix_q.a),
            .x1    (pix_q.b),
            .x2    (pix_q.c),
            .y     (row_y[r])
        );
    end

    cmx_vld_pipe #(
        .DEPTH (LATENCY)
    ) u_vld (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_en),
        .clr     (sync_clr),
        .vld_in  (in_vld),
        .vld_out (out_vld)
    );

    assign out_c0 = row_y[0];
    assign out_c1 = row_y[1];
    assign out_c2 = row_y[2];

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sync_clr) |=> (!out_vld && out_c0 == '0 && out_c1 == '0 && out_c2 == '0)); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(out_vld) && $stable(out_c0) && $stable(out_c1) && $stable(out_c2))); // R7

endmodule

// File: tb/color_matrix_conv_tb_top.sv
`timescale 1ns/1ps
module color_matrix_conv_tb_top;
    localparam int IN_W   = 8;
    localparam int COEF_W = 18;
    localparam int FULL_W = IN_W + COEF_W + 2;
    localparam int NV     = 12;

    // bit 24 = in_vld, [23:16] = c0, [15:8] = c1, [7:0] = c2
    localparam logic [24:0] VEC [NV] = '{
        25'h1_000000, 25'h1_FFFFFF, 25'h1_FF0000, 25'h0_00FF00,
        25'h1_0000FF, 25'h1_808080, 25'h0_123456, 25'h1_FEDCBA,
        25'h1_01FF01, 25'h0_FF00FF, 25'h1_7F807F, 25'h1_A5C3E1
    };

    logic clk = 1'b0;
    logic rst_n, clk_en, sync_clr, in_vld;
    logic [IN_W-1:0] in_c0, in_c1, in_c2;
    logic out_vld;
    logic [FULL_W-1:0] out_c0, out_c1, out_c2;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    color_matrix_conv dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .sync_clr (sync_clr),
        .in_vld   (in_vld),
        .in_c0    (in_c0),
        .in_c1    (in_c1),
        .in_c2    (in_c2),
        .out_vld  (out_vld),
        .out_c0   (out_c0),
        .out_c1   (out_c1),
        .out_c2   (out_c2)
    );

    function automatic longint expect_row(int row, int a, int b, int c);
        case (row)
            0:       return 263 * a + 516 * b + 100 * c + 16384;
            1:       return -152 * a - 298 * b + 450 * c + 131072;
            default: return 450 * a - 377 * b - 73 * c + 131072;
        endcase
    endfunction

    function automatic longint sval(logic [FULL_W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(input logic [24:0] v);
        in_vld = v[24];
        in_c0  = v[23:16];
        in_c1  = v[15:8];
        in_c2  = v[7:0];
    endtask

    task automatic check_pix(input logic [24:0] v, input string tag);
        longint e0, e1, e2;
        e0 = expect_row(0, int'(v[23:16]), int'(v[15:8]), int'(v[7:0]));
        e1 = expect_row(1, int'(v[23:16]), int'(v[15:8]), int'(v[7:0]));
        e2 = expect_row(2, int'(v[23:16]), int'(v[15:8]), int'(v[7:0]));
        chk(sval(out_c0) == e0, {tag, " R1 R3 R10 out_c0"}, sval(out_c0), e0);
        chk(sval(out_c1) == e1, {tag, " R2 R3 R4 out_c1"}, sval(out_c1), e1);
        chk(sval(out_c2) == e2, {tag, " R2 R3 R4 out_c2"}, sval(out_c2), e2);
        chk(out_vld == v[24], {tag, " R6 out_vld"}, longint'(out_vld), longint'(v[24]));
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [FULL_W-1:0] h0, h1, h2;
        rst_n = 1'b0; clk_en = 1'b0; sync_clr = 1'b0;
        drive(25'h0);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_vld == 1'b0, "R9 reset out_vld", longint'(out_vld), 0);
        chk(out_c0 == '0 && out_c1 == '0 && out_c2 == '0, "R9 reset outputs", sval(out_c0), 0);
        rst_n = 1'b1; clk_en = 1'b1;

        // R5/R1/R2: back-to-back stream, 4-edge latency
        for (int t = 0; t < NV + 4; t++) begin
            @(negedge clk);
            if (t >= 4) begin
                check_pix(VEC[t-4], "R5 stream");
            end else begin
                chk(out_vld == 1'b0, "R6 fill out_vld", longint'(out_vld), 0);
            end
            if (t < NV) drive(VEC[t]);
            else drive(25'h0);
        end

        // R7: stall with clear and new data ignored
        @(negedge clk);
        drive(25'h1_C8641E);
        @(negedge clk);
        clk_en = 1'b0; sync_clr = 1'b1; drive(25'h0_112233);
        h0 = out_c0; h1 = out_c1; h2 = out_c2;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(out_c0 == h0 && out_c1 == h1 && out_c2 == h2, "R7 stall holds data", sval(out_c0), sval(h0));
            chk(out_vld == 1'b0, "R7 stall out_vld", longint'(out_vld), 0);
        end
        clk_en = 1'b1; sync_clr = 1'b0; drive(25'h0);
        repeat (3) @(negedge clk);
        check_pix(25'h1_C8641E, "R7 resume");
        @(negedge clk);
        chk(out_vld == 1'b0, "R7 single pulse", longint'(out_vld), 0);

        // R8: clear flushes in-flight pixels
        drive(25'h1_FFFFFF);
        @(negedge clk);
        drive(25'h1_40A0C0);
        @(negedge clk);
        sync_clr = 1'b1; drive(25'h1_010203);
        @(negedge clk);
        chk(out_vld == 1'b0, "R8 clear out_vld", longint'(out_vld), 0);
        chk(out_c0 == '0 && out_c1 == '0 && out_c2 == '0, "R8 clear outputs", sval(out_c1), 0);
        sync_clr = 1'b0; drive(25'h0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R8 no flushed pixel", longint'(out_vld), 0);
        end
        chk(sval(out_c0) == 16384, "R8 zeros flow after clear", sval(out_c0), 16384);
        chk(sval(out_c2) == 131072, "R8 zeros flow after clear c2", sval(out_c2), 131072);

        // R9: asynchronous reset mid-flight
        drive(25'h1_FFFFFF);
        @(negedge clk);
        drive(25'h0);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        chk(out_vld == 1'b0, "R9 async out_vld", longint'(out_vld), 0);
        chk(out_c0 == '0 && out_c1 == '0 && out_c2 == '0, "R9 async outputs", sval(out_c0), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(out_vld == 1'b0, "R9 nothing after reset", longint'(out_vld), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule